// File: doc/BRIEF.md
# Nibble-Command Memory Controller

This block sits behind a byte-wide serial receiver and transmitter and runs a small command language on a single 40-bit shift memory. Each received byte carries an opcode in its low nibble and an argument nibble in its high nibble. The commands do four things:

- push a nibble into the memory;
- send the top byte of the memory to the transmitter;
- load a 32-bit snapshot from the delay-line sampler;
- run a scope capture whose 40-bit packed result replaces the whole memory.

The controller runs one command at a time. While it is busy with a command it does not accept input.

The receive side has no back-pressure. A byte that arrives while a command is still in progress is dropped.

The transmit side is valid/ready. `tx_valid` stays high, with `tx_data` held stable, until `tx_ready` is seen high at a clock edge. That edge completes the transfer.

The two capture units use a start/done handshake. A start line pulses for one cycle. The controller then waits for the matching done pulse, which must come with its result present on the same cycle.

Top module: `cmd_mem_ctrl`

## Requirements
- R1: The opcode is bits [3:0] of a received byte and the argument nibble is bits [7:4]. A byte is accepted only in a cycle where `rx_valid` is high and the controller is idle.
- R2: Opcode 4'h0 shifts the memory left by 4 and places the argument nibble in bits [3:0]. The controller stays idle afterwards.
- R3: Opcode 4'h1 raises `tx_valid` in the cycle after acceptance, with `tx_data` equal to memory bits [39:32]. Both are held until a clock edge with `tx_ready` high. At that edge the memory shifts left by 8 with zero fill, and the controller returns to idle.
- R4: Opcode 4'h2 gives a one-cycle `full_start` pulse in the cycle after acceptance and then waits. On the edge where `full_done` is high, `full_sample` is written to memory bits [31:0]. Bits [39:32] are kept.
- R5: Opcode 4'h3 gives a one-cycle `scope_start` pulse in the cycle after acceptance and then waits. On the edge where `scope_done` is high, all 40 memory bits take `scope_sample`.
- R6: Opcodes 4'h4 through 4'hF leave the memory and all outputs unchanged.
- R7: A byte that arrives while a command is executing is dropped and has no effect on the memory.
- R8: Reset clears the memory to zero, returns the controller to idle, and drives `tx_valid`, `full_start` and `scope_start` low.
- R9: A done pulse that arrives when the controller is not waiting for that capture has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte at this edge |
| tx_data | output | 8 | Byte to transmit (memory top byte) |
| full_start | output | 1 | One-cycle request for a 32-bit snapshot |
| full_done | input | 1 | Snapshot result valid |
| full_sample | input | 32 | Snapshot result |
| scope_start | output | 1 | One-cycle request for a scope capture |
| scope_done | input | 1 | Scope result valid |
| scope_sample | input | 40 | Packed scope result |

## Verification
The hardest case to reach from the ports is a byte that arrives in the middle of a command. The bench creates it in two ways. It holds `tx_ready` low while an opcode 4'h1 is pending, and it sends bytes during the gap between a capture start pulse and its done pulse. Reading back every memory byte afterwards shows that no dropped nibble or load got in. Separately, done pulses are sent while the controller is idle, to show they are ignored. A behavioural model of the memory and controller state is compared with every output on every clock.

// File: rtl/cmd_mem_pkg.sv
package cmd_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_FREQ, ST_FWAIT, ST_SREQ, ST_SWAIT
  } ctl_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_NIB, OP_SEND, OP_FULL, OP_SCOPE
  } op_e;

  typedef enum logic [2:0] {
    MA_HOLD, MA_NIB, MA_BYTE, MA_FULL, MA_SCOPE
  } mem_act_e;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_NIB   = 4'h0;
  localparam logic [CODE_W-1:0] CODE_SEND  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_FULL  = 4'h2;
  localparam logic [CODE_W-1:0] CODE_SCOPE = 4'h3;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_mem_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                     byte_valid,
  input  logic [BYTE_W-1:0]        byte_in,
  output op_e                      op,
  output logic [BYTE_W-CODE_W-1:0] arg
);
  logic [CODE_W-1:0] code;

  assign code = byte_in[CODE_W-1:0];
  assign arg  = byte_in[BYTE_W-1:CODE_W];

  always_comb begin
    op = OP_NONE;
    if (byte_valid) begin
      unique case (code)
        CODE_NIB:   op = OP_NIB;
        CODE_SEND:  op = OP_SEND;
        CODE_FULL:  op = OP_FULL;
        CODE_SCOPE: op = OP_SCOPE;
        default:    op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmd_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  logic       tx_ready,
  input  logic       full_done,
  input  logic       scope_done,
  output ctl_state_e state,
  output mem_act_e   act,
  output logic       tx_valid,
  output logic       full_start,
  output logic       scope_start
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    act     = MA_HOLD;
    unique case (state_q)
      ST_IDLE: begin
        unique case (op)
          OP_NIB:   act     = MA_NIB;
          OP_SEND:  state_d = ST_SEND;
          OP_FULL:  state_d = ST_FREQ;
          OP_SCOPE: state_d = ST_SREQ;
          default:  ;
        endcase
      end
      ST_SEND: if (tx_ready) begin
        act     = MA_BYTE;
        state_d = ST_IDLE;
      end
      ST_FREQ:  state_d = ST_FWAIT;
      ST_FWAIT: if (full_done) begin
        act     = MA_FULL;
        state_d = ST_IDLE;
      end
      ST_SREQ:  state_d = ST_SWAIT;
      ST_SWAIT: if (scope_done) begin
        act     = MA_SCOPE;
        state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state       = state_q;
  assign tx_valid    = (state_q == ST_SEND);
  assign full_start  = (state_q == ST_FREQ);
  assign scope_start = (state_q == ST_SREQ);
endmodule

// File: rtl/shift_mem.sv
module shift_mem
  import cmd_mem_pkg::*;
#(
  parameter int MEM_W  = 40,
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8,
  parameter int FULL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mem_act_e          act,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic [FULL_W-1:0] full_in,
  input  logic [MEM_W-1:0]  scope_in,
  output logic [MEM_W-1:0]  mem
);
  localparam int KEEP_W = MEM_W - FULL_W;

  logic [MEM_W-1:0] mem_q, full_next;

  generate
    if (KEEP_W > 0) begin : g_keep
      assign full_next = {mem_q[MEM_W-1:FULL_W], full_in};
    end else begin : g_all
      assign full_next = full_in[MEM_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else begin
      unique case (act)
        MA_NIB:   mem_q <= {mem_q[MEM_W-NIB_W-1:0], nib_in};
        MA_BYTE:  mem_q <= {mem_q[MEM_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        MA_FULL:  mem_q <= full_next;
        MA_SCOPE: mem_q <= scope_in;
        default:  ;
      endcase
    end
  end

  assign mem = mem_q;
endmodule

// File: rtl/cmd_mem_ctrl.sv
module cmd_mem_ctrl
  import cmd_mem_pkg::*;
#(
  parameter int MEM_W  = 40,
  parameter int BYTE_W = 8,
  parameter int FULL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              full_start,
  input  logic              full_done,
  input  logic [FULL_W-1:0] full_sample,
  output logic              scope_start,
  input  logic              scope_done,
  input  logic [MEM_W-1:0]  scope_sample
);
  localparam int NIB_W = BYTE_W - CODE_W;

  op_e                op_w;
  logic [NIB_W-1:0]   arg_w;
  ctl_state_e         state_w;
  mem_act_e           act_w;
  logic [MEM_W-1:0]   mem_w;
  logic               accept_w;

  assign accept_w = rx_valid && (state_w == ST_IDLE);

  cmd_decode #(.BYTE_W(BYTE_W)) dec_i (
    .byte_valid (accept_w),
    .byte_in    (rx_data),
    .op         (op_w),
    .arg        (arg_w)
  );

  cmd_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op_w),
    .tx_ready    (tx_ready),
    .full_done   (full_done),
    .scope_done  (scope_done),
    .state       (state_w),
    .act         (act_w),
    .tx_valid    (tx_valid),
    .full_start  (full_start),
    .scope_start (scope_start)
  );

  shift_mem #(
    .MEM_W  (MEM_W),
    .NIB_W  (NIB_W),
    .BYTE_W (BYTE_W),
    .FULL_W (FULL_W)
  ) mem_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_w),
    .nib_in   (arg_w),
    .full_in  (full_sample),
    .scope_in (scope_sample),
    .mem      (mem_w)
  );

  assign tx_data = mem_w[MEM_W-1 -: BYTE_W];
endmodule

// File: rtl/cmd_mem_ctrl_chk.sv
module cmd_mem_ctrl_chk
  import cmd_mem_pkg::*;
#(
  parameter int MEM_W  = 40,
  parameter int BYTE_W = 8,
  parameter int FULL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              full_start,
  input logic              full_done,
  input logic [FULL_W-1:0] full_sample,
  input logic              scope_start,
  input ctl_state_e        st,
  input logic [MEM_W-1:0]  mem
);
  p_send_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rx_valid && rx_data[3:0] == 4'h1) |=> tx_valid);

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_full_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_start |=> !full_start);

  p_full_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FWAIT && full_done) |=>
      (mem[MEM_W-1:FULL_W] == $past(mem[MEM_W-1:FULL_W]) &&
       mem[FULL_W-1:0] == $past(full_sample)));

  p_scope_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scope_start |=> !scope_start);

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rx_valid && rx_data[3:0] > 4'h3) |=>
      ($stable(mem) && st == ST_IDLE));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FREQ && rx_valid) |=> ($stable(mem) && st == ST_FWAIT));

  p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, full_start, scope_start}));

  p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !rx_valid) |=> ($stable(mem) && st == ST_IDLE));
endmodule

bind cmd_mem_ctrl cmd_mem_ctrl_chk #(
  .MEM_W(MEM_W), .BYTE_W(BYTE_W), .FULL_W(FULL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .full_start  (full_start),
  .full_done   (full_done),
  .full_sample (full_sample),
  .scope_start (scope_start),
  .st          (state_w),
  .mem         (mem_w)
);

// File: tb/cmd_mem_ctrl_tb_top.sv
module cmd_mem_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        full_start, scope_start;
  logic        fd_auto = 1'b0, fd_spur = 1'b0, sd_auto = 1'b0, sd_spur = 1'b0;
  logic        full_done, scope_done;
  logic [31:0] full_sample = 32'h0;
  logic [39:0] scope_sample = 40'h0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign full_done  = fd_auto | fd_spur;
  assign scope_done = sd_auto | sd_spur;

  always #10 clk = ~clk;

  cmd_mem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .full_start(full_start), .full_done(full_done), .full_sample(full_sample),
    .scope_start(scope_start), .scope_done(scope_done), .scope_sample(scope_sample)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 sending, 2 full req, 3 full wait, 4 scope req, 5 scope wait
  int          ms;
  logic [39:0] mm;
  logic [7:0]  got[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mm = '0;
    end else begin
      if (tx_valid && tx_ready) got.push_back(tx_data);
      case (ms)
        0: if (rx_valid) begin
             case (rx_data[3:0])
               4'h0: mm = {mm[35:0], rx_data[7:4]};
               4'h1: ms = 1;
               4'h2: ms = 2;
               4'h3: ms = 4;
               default: ;
             endcase
           end
        1: if (tx_ready) begin mm = mm << 8; ms = 0; end
        2: ms = 3;
        3: if (full_done) begin mm[31:0] = full_sample; ms = 0; end
        4: ms = 5;
        5: if (scope_done) begin mm = scope_sample; ms = 0; end
        default: ms = 0;
      endcase
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx_valid == (ms == 1), "R3 tx_valid", 64'(tx_valid), 64'(ms == 1));
      if (ms == 1) chk(tx_data == mm[39:32], "R3 tx_data", 64'(tx_data), 64'(mm[39:32]));
      chk(full_start == (ms == 2), "R4 full_start", 64'(full_start), 64'(ms == 2));
      chk(scope_start == (ms == 4), "R5 scope_start", 64'(scope_start), 64'(ms == 4));
    end
  end

  // capture responders: done arrives a few cycles after start
  int fcnt = 0, scnt = 0;
  always @(negedge clk) begin
    fd_auto = (fcnt == 1);
    if (fcnt > 0) fcnt--;
    if (full_start) fcnt = 4;
    sd_auto = (scnt == 1);
    if (scnt > 0) scnt--;
    if (scope_start) scnt = 5;
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0; rx_data = 8'h00;
  endtask

  task automatic wait_idle();
    while (ms != 0) @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    got.delete();
    send_byte(8'h01);
    wait_idle();
    chk(got.size() == 1, req, 64'(got.size()), 64'd1);
    if (got.size() == 1) chk(got[0] == exp, req, 64'(got[0]), 64'(exp));
  endtask

  task automatic push_nibbles(input logic [39:0] v);
    for (int i = 9; i >= 0; i--) send_byte({v[i*4 +: 4], 4'h0});
  endtask

  task automatic read_all(input logic [39:0] exp, input string req);
    for (int i = 4; i >= 0; i--) read_byte(exp[i*8 +: 8], req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid && !full_start && !scope_start, "R8 outputs in reset",
        64'({tx_valid, full_start, scope_start}), 64'd0);
    rst_n = 1'b1;
    // R8: memory reads back as zero
    read_all(40'h0, "R8 reset memory");
    // R1 R2: nibble pushes then readout
    push_nibbles(40'h123456789A);
    read_all(40'h123456789A, "R2 nibble shift");
    // R3: memory empties to zero after five reads
    read_byte(8'h00, "R3 zero fill");
    // R6: opcodes 4..F ignored
    push_nibbles(40'hFEDCBA9876);
    for (int c = 4; c < 16; c++) send_byte({4'hA, 4'(c)});
    read_all(40'hFEDCBA9876, "R6 ignored opcode");
    // R4: snapshot keeps top byte
    push_nibbles(40'h123456789A);
    full_sample = 32'hDEADBEEF;
    send_byte(8'h02); wait_idle();
    full_sample = 32'h0;
    read_all(40'h12DEADBEEF, "R4 full load");
    // R5: scope replaces all bits
    push_nibbles(40'h1111111111);
    scope_sample = 40'hC35A0FF099;
    send_byte(8'h03); wait_idle();
    scope_sample = 40'h0;
    read_all(40'hC35A0FF099, "R5 scope load");
    // R7: bytes during stalled send are dropped
    push_nibbles(40'h123456789A);
    got.delete();
    tx_ready = 1'b0;
    send_byte(8'h01);
    send_byte(8'h70);
    send_byte(8'h02);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R3 back-pressure holds", 64'(got.size()), 64'd0);
    tx_ready = 1'b1;
    wait_idle();
    chk(got.size() == 1 && got[0] == 8'h12, "R7 stalled send byte",
        64'(got.size() > 0 ? got[0] : 8'hxx), 64'h12);
    // R7: bytes during capture wait are dropped
    full_sample = 32'h55AA55AA;
    send_byte(8'h02);
    send_byte(8'h90);
    send_byte(8'h03);
    wait_idle();
    full_sample = 32'h0;
    read_all(40'h3455AA55AA, "R7 dropped during capture");
    // R9: stray done pulses while idle
    push_nibbles(40'h0102030405);
    full_sample = 32'hFFFFFFFF; scope_sample = 40'hFFFFFFFFFF;
    @(negedge clk); fd_spur = 1'b1; sd_spur = 1'b1;
    @(negedge clk); fd_spur = 1'b0; sd_spur = 1'b0;
    full_sample = 32'h0; scope_sample = 40'h0;
    read_all(40'h0102030405, "R9 stray done");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule